// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block steers a set of external interrupt sources onto the interrupt pins of several processor cores. Every source has its own enable, a pending flag, a destination core and a destination pin. Each core/pin output is the OR of all sources routed there that are both pending and enabled. A per-core local timer request is also ORed onto a pin chosen by software, subject to a per-core mask bit.

Software controls the block through a 32-bit register port with a one-cycle read response. Enables are changed in bulk through separate write-one-to-set and write-one-to-clear words. Pending and enable state can be read back as packed words. A trigger register lets software force one source's pending flag high or low. Each source has a pin-map word and a one-hot core-map word. Each core has a local-route word and a local-mask word.

Byte offsets (bits [1:0] ignored): pending words 0x040+4w, enable words 0x080+4w, set-enable 0x100+4w, clear-enable 0x140+4w, trigger 0x180, pin map 0x400+4s, core map 0x800+4s, local route 0xC00+4c, local mask 0xC40+4c. Word w covers sources 32w to 32w+31.

Top module: `shared_irq_router`

## Requirements
- R1: Output irq_o[c*NUM_PIN+p] is high exactly when some source is enabled, pending, mapped to core c and has pin p, or when timer_req_i[c] is high, core c's local mask bit is 1 and its local pin is p. The output follows register state combinationally.
- R2: A source's pending flag takes the new input level on the clock edge after any change of that input, whether or not the source is enabled. A disabled source never drives an output.
- R3: A write to set-enable word w enables source 32w+b for every data bit b that is 1. A write to clear-enable word w disables those sources. Zero bits change nothing.
- R4: Reading pending word w or enable word w returns the flags of sources 32w..32w+31, with bit b for source 32w+b. Bits for sources that do not exist read 0.
- R5: A trigger write with source number data[7:0] below NUM_SRC sets that source's pending flag when data[31]=1 and clears it when data[31]=0. If the trigger and an input change hit the same source in the same cycle, the trigger wins.
- R6: A trigger write whose source number is NUM_SRC or more changes no pending flag.
- R7: A core-map write stores the index of the lowest set data bit. An all-zero write marks the source unmapped. A write whose lowest set bit is NUM_CORE or more is rejected. A read returns the one-hot form (1<<core), or 0 when unmapped.
- R8: A pin-map or local-route write stores the pin field data[5:0] and the route flag data[31]. If the pin field exceeds NUM_PIN-1, the whole write is rejected and the stored value is unchanged. Readback is {flag, 25'b0, pin}.
- R9: After reset, every source is disabled, not pending and unmapped, with pin map 0x8000_0000. Every core has local route 0x8000_0000 and local mask 0. All outputs are low.
- R10: The local-mask write stores data[0]. A timer request reaches its core's local pin only while that bit is 1.
- R11: Read data appears on the cycle after the read strobe. Reads of undefined or out-of-range addresses return 0, and so does the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level_i | input | NUM_SRC | Interrupt source levels |
| timer_req_i | input | NUM_CORE | Local timer request per core |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | NUM_CORE*NUM_PIN | Core interrupt pins, index core*NUM_PIN+pin |

## Verification
The block has three timings. A register write or an input change moves the stored state on the next rising edge. The interrupt outputs then follow that state in the same cycle, with no further register. Read data lands one edge after the strobe.

The bench applies each stimulus just after a falling edge and advances a behavioural model to the state after the coming rising edge. At the next falling edge it compares every output pin against the model. When a read was issued, it also compares the read data, computed from the model state before the write. timer_req_i enters the output with no register, so the model evaluates it at the moment of comparison.

// File: rtl/isr_pkg.sv
// Package: shared constants and types for the interrupt source router.
// Assumes a 12-bit byte address and a 32-bit data word.
package isr_pkg;
    localparam int TRIG_FIELD_W = 8;   // source number field of the trigger word
    localparam int PIN_FIELD_W  = 6;   // pin field of map words
    localparam int DIR_BIT      = 31;  // trigger direction bit
    localparam int FLAG_BIT     = 31;  // route-to-pin flag bit

    localparam logic [11:0] PEND_BASE    = 12'h040;
    localparam logic [11:0] EN_BASE      = 12'h080;
    localparam logic [11:0] SET_BASE     = 12'h100;
    localparam logic [11:0] CLR_BASE     = 12'h140;
    localparam logic [11:0] TRIG_ADDR    = 12'h180;
    localparam logic [11:0] PINMAP_BASE  = 12'h400;
    localparam logic [11:0] COREMAP_BASE = 12'h800;
    localparam logic [11:0] LROUTE_BASE  = 12'hC00;
    localparam logic [11:0] LMASK_BASE   = 12'hC40;

    typedef enum logic [3:0] {
        RG_NONE, RG_PEND, RG_EN, RG_SET, RG_CLR, RG_TRIG,
        RG_PINMAP, RG_COREMAP, RG_LROUTE, RG_LMASK
    } region_e;
endpackage

// File: rtl/isr_src_bank.sv
// Module: per-source state (enable, pending, pin map, core map).
// Assumes at most one write strobe is active per cycle. A trigger takes
// precedence over an input level change. Map writes with an illegal
// pin or core are dropped.
module isr_src_bank
    import isr_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                level_i,
    input  logic                              set_we_i,
    input  logic                              clr_we_i,
    input  logic                              trig_we_i,
    input  logic                              pin_we_i,
    input  logic                              core_we_i,
    input  logic [((NUM_SRC+31)/32>1 ? $clog2((NUM_SRC+31)/32) : 1)-1:0] word_i,
    input  logic [(NUM_SRC>1 ? $clog2(NUM_SRC) : 1)-1:0] idx_i,
    input  logic [31:0]                       wdata_i,
    output logic [NUM_SRC-1:0]                en_o,
    output logic [NUM_SRC-1:0]                pend_o,
    output logic [NUM_SRC-1:0]                flag_o,
    output logic [NUM_SRC-1:0][(NUM_PIN>1 ? $clog2(NUM_PIN) : 1)-1:0] pin_o,
    output logic [NUM_SRC-1:0]                core_vld_o,
    output logic [NUM_SRC-1:0][(NUM_CORE>1 ? $clog2(NUM_CORE) : 1)-1:0] core_o
);
    localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
    localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int PIN_W     = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
    localparam int CORE_W    = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

    logic [NUM_SRC-1:0] lvl_q;
    logic [4:0]         low_bit;
    logic               core_ok;
    logic               pin_ok;
    logic               trig_ok;
    logic [TRIG_FIELD_W-1:0] trig_src;
    logic [PIN_FIELD_W-1:0]  pin_field;

    // Find the lowest set bit of the core-map data word
    always_comb begin
        low_bit = '0;
        for (int i = 31; i >= 0; i--) begin
            if (wdata_i[i]) low_bit = 5'(i);
        end
    end

    // Legality of map and trigger fields
    always_comb begin
        trig_src  = wdata_i[TRIG_FIELD_W-1:0];
        pin_field = wdata_i[PIN_FIELD_W-1:0];
        core_ok   = (wdata_i == '0) || (int'(low_bit) < NUM_CORE);
        pin_ok    = int'(pin_field) < NUM_PIN;
        trig_ok   = trig_we_i && (int'(trig_src) < NUM_SRC);
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic set_hit, clr_hit, trig_hit, pin_hit, core_hit;

        // Per-source write decode
        always_comb begin
            set_hit  = set_we_i && (word_i == WORD_W'(s / 32)) && wdata_i[s % 32];
            clr_hit  = clr_we_i && (word_i == WORD_W'(s / 32)) && wdata_i[s % 32];
            trig_hit = trig_ok && (trig_src == TRIG_FIELD_W'(s));
            pin_hit  = pin_we_i && (idx_i == SRC_W'(s)) && pin_ok;
            core_hit = core_we_i && (idx_i == SRC_W'(s)) && core_ok;
        end

        // Source state registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[s]      <= 1'b0;
                en_o[s]       <= 1'b0;
                pend_o[s]     <= 1'b0;
                flag_o[s]     <= 1'b1;
                pin_o[s]      <= '0;
                core_vld_o[s] <= 1'b0;
                core_o[s]     <= '0;
            end else begin
                lvl_q[s] <= level_i[s];
                if (set_hit)      en_o[s] <= 1'b1;
                else if (clr_hit) en_o[s] <= 1'b0;
                if (trig_hit)                     pend_o[s] <= wdata_i[DIR_BIT];
                else if (level_i[s] != lvl_q[s])  pend_o[s] <= level_i[s];
                if (pin_hit) begin
                    flag_o[s] <= wdata_i[FLAG_BIT];
                    pin_o[s]  <= PIN_W'(pin_field);
                end
                if (core_hit) begin
                    core_vld_o[s] <= (wdata_i != '0);
                    core_o[s]     <= CORE_W'(low_bit);
                end
            end
        end

        // R3
        set_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_we_i && word_i == WORD_W'(s / 32) && wdata_i[s % 32]) |=> en_o[s]);
        // R3
        clr_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && word_i == WORD_W'(s / 32) && wdata_i[s % 32]) |=> !en_o[s]);
        // R5
        trig_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_we_i && wdata_i[TRIG_FIELD_W-1:0] == TRIG_FIELD_W'(s))
            |=> (pend_o[s] == $past(wdata_i[DIR_BIT])));
        // R8
        pin_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_we_i && idx_i == SRC_W'(s) && int'(wdata_i[PIN_FIELD_W-1:0]) >= NUM_PIN)
            |=> ($stable(pin_o[s]) && $stable(flag_o[s])));
    end
endmodule

// File: rtl/isr_local_bank.sv
// Module: per-core local timer route (flag and pin) and local mask.
// Assumes the same pin legality rule as the source pin map.
module isr_local_bank
    import isr_pkg::*;
#(
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         route_we_i,
    input  logic                         mask_we_i,
    input  logic [(NUM_CORE>1 ? $clog2(NUM_CORE) : 1)-1:0] idx_i,
    input  logic                         flag_i,
    input  logic [PIN_FIELD_W-1:0]       pin_field_i,
    input  logic                         mask_i,
    output logic [NUM_CORE-1:0]          lflag_o,
    output logic [NUM_CORE-1:0][(NUM_PIN>1 ? $clog2(NUM_PIN) : 1)-1:0] lpin_o,
    output logic [NUM_CORE-1:0]          lmask_o
);
    localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
    localparam int PIN_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;

    logic pin_ok;

    // Reject pin numbers beyond the last core pin
    always_comb pin_ok = int'(pin_field_i) < NUM_PIN;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        // Local route and mask registers of one core
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lflag_o[c] <= 1'b1;
                lpin_o[c]  <= '0;
                lmask_o[c] <= 1'b0;
            end else begin
                if (route_we_i && idx_i == CORE_W'(c) && pin_ok) begin
                    lflag_o[c] <= flag_i;
                    lpin_o[c]  <= PIN_W'(pin_field_i);
                end
                if (mask_we_i && idx_i == CORE_W'(c)) lmask_o[c] <= mask_i;
            end
        end

        // R10
        mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we_i && idx_i == CORE_W'(c)) |=> (lmask_o[c] == $past(mask_i)));
    end
endmodule

// File: rtl/isr_route_or.sv
// Module: combinational OR network from source and local state to core pins.
// Assumes the state inputs are registered upstream. clk and rst_n serve
// only the checks.
module isr_route_or #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            en_i,
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0]            core_vld_i,
    input  logic [NUM_SRC-1:0][(NUM_CORE>1 ? $clog2(NUM_CORE) : 1)-1:0] core_i,
    input  logic [NUM_SRC-1:0][(NUM_PIN>1 ? $clog2(NUM_PIN) : 1)-1:0]   pin_i,
    input  logic [NUM_CORE-1:0]           timer_i,
    input  logic [NUM_CORE-1:0]           lmask_i,
    input  logic [NUM_CORE-1:0][(NUM_PIN>1 ? $clog2(NUM_PIN) : 1)-1:0]  lpin_i,
    output logic [NUM_CORE*NUM_PIN-1:0]   irq_o
);
    localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
    localparam int PIN_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic hit;
            // OR of every live source routed to this core/pin plus the local timer
            always_comb begin
                hit = timer_i[c] && lmask_i[c] && (lpin_i[c] == PIN_W'(p));
                for (int s = 0; s < NUM_SRC; s++) begin
                    hit = hit | (en_i[s] & pend_i[s] & core_vld_i[s] &
                                 (core_i[s] == CORE_W'(c)) & (pin_i[s] == PIN_W'(p)));
                end
            end
            assign irq_o[c*NUM_PIN+p] = hit;
        end
    end

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((en_i & pend_i) == '0) && ((timer_i & lmask_i) == '0)) |-> (irq_o == '0));
    // R2
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_i == '0) && ((timer_i & lmask_i) == '0)) |-> (irq_o == '0));
endmodule

// File: rtl/shared_irq_router.sv
// Module: top of the shared interrupt source router. It decodes the
// register port, holds the one-cycle read data register and joins the
// source bank, the local bank and the OR network.
// Assumes NUM_SRC is a nonzero multiple of 8, at most 256, and NUM_CORE <= 16.
module shared_irq_router
    import isr_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           src_level_i,
    input  logic [NUM_CORE-1:0]          timer_req_i,
    input  logic                         bus_wr_i,
    input  logic                         bus_rd_i,
    input  logic [11:0]                  bus_addr_i,
    input  logic [31:0]                  bus_wdata_i,
    output logic [31:0]                  bus_rdata_o,
    output logic [NUM_CORE*NUM_PIN-1:0]  irq_o
);
    localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
    localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int PIN_W     = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
    localparam int CORE_W    = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
    localparam logic [11:0] PEND_END    = PEND_BASE + 12'(4 * NUM_WORDS);
    localparam logic [11:0] EN_END      = EN_BASE + 12'(4 * NUM_WORDS);
    localparam logic [11:0] SET_END     = SET_BASE + 12'(4 * NUM_WORDS);
    localparam logic [11:0] CLR_END     = CLR_BASE + 12'(4 * NUM_WORDS);
    localparam logic [11:0] PINMAP_END  = PINMAP_BASE + 12'(4 * NUM_SRC);
    localparam logic [11:0] COREMAP_END = COREMAP_BASE + 12'(4 * NUM_SRC);
    localparam logic [11:0] LROUTE_END  = LROUTE_BASE + 12'(4 * NUM_CORE);
    localparam logic [11:0] LMASK_END   = LMASK_BASE + 12'(4 * NUM_CORE);

    region_e     rgn;
    logic [11:0] wa;
    logic [11:0] off;
    logic [9:0]  idx;
    logic [31:0] rd_next;
    logic [NUM_WORDS*32-1:0] pend_pad, en_pad;

    logic [NUM_SRC-1:0] en, pend, flag, core_vld;
    logic [NUM_SRC-1:0][PIN_W-1:0]  pin;
    logic [NUM_SRC-1:0][CORE_W-1:0] core;
    logic [NUM_CORE-1:0] lflag, lmask;
    logic [NUM_CORE-1:0][PIN_W-1:0] lpin;

    // Address decode into a region and an entry index
    always_comb begin
        wa  = {bus_addr_i[11:2], 2'b00};
        rgn = RG_NONE;
        off = '0;
        if      (wa >= PEND_BASE    && wa < PEND_END)    begin rgn = RG_PEND;    off = wa - PEND_BASE;    end
        else if (wa >= EN_BASE      && wa < EN_END)      begin rgn = RG_EN;      off = wa - EN_BASE;      end
        else if (wa >= SET_BASE     && wa < SET_END)     begin rgn = RG_SET;     off = wa - SET_BASE;     end
        else if (wa >= CLR_BASE     && wa < CLR_END)     begin rgn = RG_CLR;     off = wa - CLR_BASE;     end
        else if (wa == TRIG_ADDR)                        begin rgn = RG_TRIG;                             end
        else if (wa >= PINMAP_BASE  && wa < PINMAP_END)  begin rgn = RG_PINMAP;  off = wa - PINMAP_BASE;  end
        else if (wa >= COREMAP_BASE && wa < COREMAP_END) begin rgn = RG_COREMAP; off = wa - COREMAP_BASE; end
        else if (wa >= LROUTE_BASE  && wa < LROUTE_END)  begin rgn = RG_LROUTE;  off = wa - LROUTE_BASE;  end
        else if (wa >= LMASK_BASE   && wa < LMASK_END)   begin rgn = RG_LMASK;   off = wa - LMASK_BASE;   end
        idx = off[11:2];
    end

    // Pad packed flag vectors to whole words
    always_comb begin
        pend_pad = '0;
        en_pad   = '0;
        pend_pad[NUM_SRC-1:0] = pend;
        en_pad[NUM_SRC-1:0]   = en;
    end

    // Read data multiplexer
    always_comb begin
        rd_next = '0;
        case (rgn)
            RG_PEND:    rd_next = pend_pad[32*int'(idx[WORD_W-1:0]) +: 32];
            RG_EN:      rd_next = en_pad[32*int'(idx[WORD_W-1:0]) +: 32];
            RG_PINMAP:  rd_next = {flag[idx[SRC_W-1:0]], {(31-PIN_FIELD_W){1'b0}},
                                   PIN_FIELD_W'(pin[idx[SRC_W-1:0]])};
            RG_COREMAP: rd_next = core_vld[idx[SRC_W-1:0]] ?
                                  (32'd1 << core[idx[SRC_W-1:0]]) : 32'd0;
            RG_LROUTE:  rd_next = {lflag[idx[CORE_W-1:0]], {(31-PIN_FIELD_W){1'b0}},
                                   PIN_FIELD_W'(lpin[idx[CORE_W-1:0]])};
            RG_LMASK:   rd_next = {31'd0, lmask[idx[CORE_W-1:0]]};
            default:    rd_next = '0;
        endcase
    end

    // One-cycle registered read response, zero when no read
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_next;
        else               bus_rdata_o <= '0;
    end

    isr_src_bank #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (src_level_i),
        .set_we_i   (bus_wr_i && rgn == RG_SET),
        .clr_we_i   (bus_wr_i && rgn == RG_CLR),
        .trig_we_i  (bus_wr_i && rgn == RG_TRIG),
        .pin_we_i   (bus_wr_i && rgn == RG_PINMAP),
        .core_we_i  (bus_wr_i && rgn == RG_COREMAP),
        .word_i     (idx[WORD_W-1:0]),
        .idx_i      (idx[SRC_W-1:0]),
        .wdata_i    (bus_wdata_i),
        .en_o       (en),
        .pend_o     (pend),
        .flag_o     (flag),
        .pin_o      (pin),
        .core_vld_o (core_vld),
        .core_o     (core)
    );

    isr_local_bank #(.NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_local (
        .clk         (clk),
        .rst_n       (rst_n),
        .route_we_i  (bus_wr_i && rgn == RG_LROUTE),
        .mask_we_i   (bus_wr_i && rgn == RG_LMASK),
        .idx_i       (idx[CORE_W-1:0]),
        .flag_i      (bus_wdata_i[FLAG_BIT]),
        .pin_field_i (bus_wdata_i[PIN_FIELD_W-1:0]),
        .mask_i      (bus_wdata_i[0]),
        .lflag_o     (lflag),
        .lpin_o      (lpin),
        .lmask_o     (lmask)
    );

    isr_route_or #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_or (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .pend_i     (pend),
        .core_vld_i (core_vld),
        .core_i     (core),
        .pin_i      (pin),
        .timer_i    (timer_req_i),
        .lmask_i    (lmask),
        .lpin_i     (lpin),
        .irq_o      (irq_o)
    );

    // R11
    undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && rgn == RG_NONE) |=> (bus_rdata_o == '0));
    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> (bus_rdata_o == '0));
endmodule

// File: tb/shared_irq_router_bench.sv
// Bench: behavioural reference model advanced once per clock and compared
// at every falling edge against the interrupt pins and read data.
module shared_irq_router_bench;
    localparam int NS = 32;
    localparam int NC = 4;
    localparam int NP = 6;
    localparam int NW = (NS + 31) / 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] lvl = '0;
    logic [NC-1:0] tmr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC*NP-1:0] irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    bit m_en[NS], m_pend[NS], m_prev[NS], m_flag[NS];
    int m_pin[NS], m_core[NS];
    bit m_lflag[NC], m_lmask[NC];
    int m_lpin[NC];

    always #10 clk = ~clk;

    shared_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) u_shared_irq_router (
        .clk(clk), .rst_n(rst_n), .src_level_i(lvl), .timer_req_i(tmr),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_en[s] = 0; m_pend[s] = 0; m_prev[s] = 0; m_flag[s] = 1;
            m_pin[s] = 0; m_core[s] = -1;
        end
        for (int c = 0; c < NC; c++) begin
            m_lflag[c] = 1; m_lmask[c] = 0; m_lpin[c] = 0;
        end
    endtask

    function automatic logic [NC*NP-1:0] model_irq();
        logic [NC*NP-1:0] r = '0;
        for (int s = 0; s < NS; s++)
            if (m_en[s] && m_pend[s] && m_core[s] >= 0) r[m_core[s]*NP + m_pin[s]] = 1'b1;
        for (int c = 0; c < NC; c++)
            if (tmr[c] && m_lmask[c]) r[c*NP + m_lpin[c]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a0);
        int a = int'({a0[11:2], 2'b00});
        logic [31:0] r = '0;
        if (a >= 'h040 && a < 'h040 + 4*NW) begin
            for (int b = 0; b < 32; b++)
                if ((a - 'h040)/4*32 + b < NS) r[b] = m_pend[(a - 'h040)/4*32 + b];
        end else if (a >= 'h080 && a < 'h080 + 4*NW) begin
            for (int b = 0; b < 32; b++)
                if ((a - 'h080)/4*32 + b < NS) r[b] = m_en[(a - 'h080)/4*32 + b];
        end else if (a >= 'h400 && a < 'h400 + 4*NS) begin
            r = {m_flag[(a-'h400)/4], 31'(m_pin[(a-'h400)/4])};
        end else if (a >= 'h800 && a < 'h800 + 4*NS) begin
            if (m_core[(a-'h800)/4] >= 0) r = 32'd1 << m_core[(a-'h800)/4];
        end else if (a >= 'hC00 && a < 'hC00 + 4*NC) begin
            r = {m_lflag[(a-'hC00)/4], 31'(m_lpin[(a-'hC00)/4])};
        end else if (a >= 'hC40 && a < 'hC40 + 4*NC) begin
            r = {31'd0, m_lmask[(a-'hC40)/4]};
        end
        return r;
    endfunction

    task automatic model_step(bit wr, logic [11:0] a0, logic [31:0] d);
        int a = int'({a0[11:2], 2'b00});
        int tsrc = -1;
        bit tdir = d[31];
        if (wr) begin
            if (a >= 'h100 && a < 'h100 + 4*NW) begin
                for (int b = 0; b < 32; b++)
                    if (d[b] && (a-'h100)/4*32 + b < NS) m_en[(a-'h100)/4*32 + b] = 1;
            end else if (a >= 'h140 && a < 'h140 + 4*NW) begin
                for (int b = 0; b < 32; b++)
                    if (d[b] && (a-'h140)/4*32 + b < NS) m_en[(a-'h140)/4*32 + b] = 0;
            end else if (a == 'h180) begin
                if (int'(d[7:0]) < NS) tsrc = int'(d[7:0]);
            end else if (a >= 'h400 && a < 'h400 + 4*NS) begin
                if (int'(d[5:0]) < NP) begin
                    m_flag[(a-'h400)/4] = d[31]; m_pin[(a-'h400)/4] = int'(d[5:0]);
                end
            end else if (a >= 'h800 && a < 'h800 + 4*NS) begin
                if (d == 0) m_core[(a-'h800)/4] = -1;
                else begin
                    int low = 0;
                    for (int b = 31; b >= 0; b--) if (d[b]) low = b;
                    if (low < NC) m_core[(a-'h800)/4] = low;
                end
            end else if (a >= 'hC00 && a < 'hC00 + 4*NC) begin
                if (int'(d[5:0]) < NP) begin
                    m_lflag[(a-'hC00)/4] = d[31]; m_lpin[(a-'hC00)/4] = int'(d[5:0]);
                end
            end else if (a >= 'hC40 && a < 'hC40 + 4*NC) begin
                m_lmask[(a-'hC40)/4] = d[0];
            end
        end
        for (int s = 0; s < NS; s++) begin
            if (s == tsrc) m_pend[s] = tdir;
            else if (lvl[s] != m_prev[s]) m_pend[s] = lvl[s];
            m_prev[s] = lvl[s];
        end
    endtask

    // One clock: drive, advance model, compare at the falling edge
    task automatic tick(string tag, bit wr, bit rd, logic [11:0] a, logic [31:0] d);
        logic [31:0] exp_rd;
        logic [NC*NP-1:0] exp_irq;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        exp_rd = rd ? model_read(a) : 32'd0;
        model_step(wr, a, d);
        @(negedge clk);
        exp_irq = model_irq();
        checks++;
        if (irq !== exp_irq) begin
            fails++;
            $display("FAIL R1 %s irq actual=%h expected=%h", tag, irq, exp_irq);
        end
        checks++;
        if (bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp_rd);
        end
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
        tick(tag, 1, 0, a, d);
    endtask
    task automatic rd(string tag, logic [11:0] a);
        tick(tag, 0, 1, a, 32'd0);
    endtask
    task automatic idle(string tag);
        tick(tag, 0, 0, 12'h000, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd("R9 pend", 12'h040);
        rd("R9 en", 12'h080);
        rd("R9 pinmap", 12'h404);
        rd("R9 coremap", 12'h804);
        rd("R9 lroute", 12'hC04);
        rd("R9 lmask", 12'hC44);
        // R11 undefined and out-of-range addresses
        rd("R11 undef", 12'h000);
        rd("R11 pend word1", 12'h044);
        rd("R11 top", 12'hFFC);
        idle("R11 idle");
        // R2 pending follows level while disabled
        wr("R7 core map", 12'h80C, 32'h2);
        wr("R8 pin map", 12'h40C, 32'h2);
        lvl[3] = 1'b1;
        idle("R2 level rise disabled");
        rd("R2 pend read", 12'h040);
        // R3 enable
        wr("R3 set enable", 12'h100, 32'h8);
        rd("R4 enable read", 12'h080);
        // R7 lowest bit and readback
        wr("R7 multi-hot", 12'h80C, 32'hC);
        rd("R7 readback", 12'h80C);
        wr("R7 out of range", 12'h80C, 32'h100);
        rd("R7 unchanged", 12'h80C);
        wr("R7 unmap", 12'h80C, 32'h0);
        rd("R7 unmapped read", 12'h80C);
        wr("R7 remap", 12'h80C, 32'h1);
        // R8 pin reject
        wr("R8 bad pin", 12'h40C, 32'h0000_0007);
        rd("R8 unchanged", 12'h40C);
        wr("R8 good pin", 12'h40C, 32'h8000_0005);
        rd("R8 new pin", 12'h40C);
        // R5 trigger
        wr("R7 map 10", 12'h828, 32'h1);
        wr("R3 enable 10", 12'h100, 32'h400);
        wr("R5 trig set", 12'h180, 32'h8000_000A);
        rd("R5 pend set", 12'h040);
        wr("R5 trig clr", 12'h180, 32'h0000_000A);
        rd("R5 pend clr", 12'h040);
        // R6 out-of-range trigger
        wr("R6 trig 40", 12'h180, 32'h8000_0028);
        rd("R6 pend same", 12'h040);
        wr("R6 trig 200", 12'h180, 32'h8000_00C8);
        rd("R6 pend same2", 12'h040);
        // R1 two sources on one pin
        wr("R7 map 11", 12'h82C, 32'h1);
        wr("R3 enable 11", 12'h100, 32'h800);
        wr("R5 trig 10", 12'h180, 32'h8000_000A);
        wr("R5 trig 11", 12'h180, 32'h8000_000B);
        wr("R1 drop one", 12'h180, 32'h0000_000A);
        wr("R1 drop other", 12'h180, 32'h0000_000B);
        // R3 clear enable
        wr("R3 clear 3", 12'h140, 32'h8);
        rd("R3 enable read", 12'h080);
        // R2 level fall
        lvl[3] = 1'b0;
        idle("R2 level fall");
        rd("R2 pend after fall", 12'h040);
        // R10 local timer route and mask
        tmr[2] = 1'b1;
        idle("R10 masked");
        wr("R10 route", 12'hC08, 32'h4);
        wr("R10 unmask", 12'hC48, 32'h1);
        wr("R8 local bad pin", 12'hC08, 32'h6);
        rd("R8 local unchanged", 12'hC08);
        tmr[2] = 1'b0;
        idle("R10 timer low");
        wr("R10 mask off", 12'hC48, 32'h0);
        tmr[2] = 1'b1;
        idle("R10 masked again");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 9));
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 3) == 0) lvl = $urandom;
            tmr = 4'($urandom);
            case (op)
                0: wr("R3 rnd set", 12'h100, d & $urandom);
                1: wr("R3 rnd clr", 12'h140, d & $urandom);
                2: wr("R5 rnd trig", 12'h180, {d[31], 23'd0, 8'($urandom_range(0, 40))});
                3: wr("R8 rnd pin", 12'(12'h400 + 4*$urandom_range(0, NS-1)), {d[31], 25'd0, 6'($urandom_range(0, 7))});
                4: wr("R7 rnd core", 12'(12'h800 + 4*$urandom_range(0, NS-1)), 32'd1 << $urandom_range(0, 5));
                5: wr("R10 rnd lroute", 12'(12'hC00 + 4*$urandom_range(0, NC-1)), {d[31], 25'd0, 6'($urandom_range(0, 7))});
                6: wr("R10 rnd lmask", 12'(12'hC40 + 4*$urandom_range(0, NC-1)), d);
                7: rd("R4 rnd pend", 12'h040);
                8: rd("R4 rnd en", 12'h080);
                default: rd("R11 rnd read", 12'($urandom));
            endcase
        end
        finish_run();
    end
endmodule